// File: doc/BRIEF.md
# SPI Flash Read Timing Calibration Sequencer

This block trains the read-sampling point of an SPI flash link without software help. After a start request it has a checksum-read engine fetch a fixed region of the flash at the slowest clock, and keeps the result as the reference value. It then sets faster clock divisors in turn. For each divisor it steps through the input-delay settings until the engine returns the reference checksum again.

For every divisor the first delay that reproduces the reference is stored in a packed timing word, and a pass bit is set. A ceiling input stops divisors that would run the flash too fast from being tried at all. The engine is driven through a start pulse, a 12-bit control word, a done pulse and the checksum it returns. The finished timing word is ready to load into the controller's read-timing register.

Top module: `spi_read_tuner`

## Requirements
- R1: During and right after reset, `timingWord`, `passMask`, `calDone` and `engStart` are all zero.
- R2: The first read after an accepted start uses control word 0x000: divider code 0 (clock divided by 16) and delay 0. The checksum it returns becomes the reference.
- R3: After the reference, divisors are tried in the order divide-by-5, 4, 3, 2, 1. The divider code sits in control bits 7:4 and takes the values 13, 6, 14, 7, 15 in that order. Control bits 3:0 are zero.
- R4: For each tried divisor, the delay field in control bits 11:8 is the delay count plus 8 (bit 3 set). Counts run 0 to 5 in increasing order, and the search for that divisor stops at the first checksum equal to the reference.
- R5: When a divisor divide-by-N passes, bits (N-1)*4+3 to (N-1)*4 of `timingWord` hold the passing delay field value, and `passMask` bit N-1 is set.
- R6: A divisor that fails all six delay counts is left with a zero field and a clear pass bit. Exactly six reads are issued for it before the next divisor starts.
- R7: A divisor N with N less than `divFloor` is skipped. No read is issued for it, its field stays zero and its pass bit stays clear.
- R8: `calDone` is high for one cycle after the last divisor has been handled. `timingWord` bits 31:20 are always zero. Both results hold their values until the next accepted start.
- R9: A start request that arrives while a calibration is running is ignored. The running sequence and its read count are unchanged.
- R10: `engStart` is high for exactly one cycle per read. `engCtrl` does not change between that pulse and the matching `engDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startCal | input | 1 | Request a calibration run (taken only when idle) |
| divFloor | input | 3 | Smallest divisor allowed by the frequency ceiling |
| engStart | output | 1 | One-cycle request for a checksum read |
| engCtrl | output | 12 | Engine control: delay 11:8, divider code 7:4, zero 3:0 |
| engDone | input | 1 | One-cycle pulse: the current read has finished |
| engSum | input | 32 | Checksum returned with `engDone` |
| calDone | output | 1 | One-cycle pulse at the end of a run |
| timingWord | output | 32 | Packed per-divisor delay fields |
| passMask | output | 5 | Bit N-1 set when divide-by-N found a working delay |

## Verification
The assertions assume the engine answers every `engStart` with exactly one `engDone`. They also assume `engDone` never arrives without a read outstanding, and never in the same cycle as the start pulse. The bench engine model keeps to this. It waits several cycles after each start, then raises done for one cycle with a checksum that depends only on the control word it latched. It marks each divisor as passing from a chosen delay count onward. The bench also drives `startCal` only from negative edges, so the checker sees the same accepted starts as the sequencer does.

// File: rtl/spi_tune_pkg.sv
package spi_tune_pkg;

  localparam int NUM_DIV  = 5;   // candidate divisors 1..NUM_DIV
  localparam int MAX_DLY  = 5;   // highest delay count tried
  localparam int FIELD_W  = 4;   // width of one timing field / delay field
  localparam int DLY_BIAS = 8;   // fixed extra input delay flag
  localparam int REF_DIV  = 16;  // divisor used for the reference read
  localparam int IDX_W    = $clog2(NUM_DIV + 1);
  localparam int CNT_W    = $clog2(MAX_DLY + 1);
  localparam int FLOOR_W  = $clog2(NUM_DIV + 2);
  localparam int CTRL_W   = 3 * FIELD_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REF_GO, ST_REF_WAIT, ST_PICK, ST_RD_GO, ST_RD_WAIT, ST_FINISH
  } tuneState_t;

  // Strobes and current position handed from control to datapath
  typedef struct packed {
    logic             clearAll;
    logic             takeGolden;
    logic             recordHit;
    logic             refMode;
    logic [IDX_W-1:0] divIdx;
    logic [CNT_W-1:0] dlyCnt;
  } tuneStrobe_t;

  // Divider encoding: odd divisors carry bit 3, the rest is (16-n)/2
  function automatic logic [FIELD_W-1:0] divCode(input int n);
    int v;
    v = (REF_DIV - n) >> 1;
    if (n % 2 == 1) v = v | 8;
    return FIELD_W'(v);
  endfunction

endpackage

// File: rtl/spi_tune_ctrl.sv
module spi_tune_ctrl
  import spi_tune_pkg::*;
#(
  parameter int NDIV = NUM_DIV,
  parameter int MDLY = MAX_DLY
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startCal,
  input  logic [FLOOR_W-1:0] divFloor,
  input  logic               engDone,
  input  logic               sumMatch,
  output tuneStrobe_t        stb,
  output logic               engStart,
  output logic               calDone
);

  tuneState_t       state;
  logic [IDX_W-1:0] divIdx;
  logic [CNT_W-1:0] dlyCnt;
  logic             lastDiv;
  logic             overCeiling;

  assign lastDiv     = (int'(divIdx) == NDIV - 1);
  assign overCeiling = (NDIV - int'(divIdx)) < int'(divFloor);

  always_comb begin
    stb            = '0;
    stb.divIdx     = divIdx;
    stb.dlyCnt     = dlyCnt;
    stb.refMode    = (state == ST_REF_GO) || (state == ST_REF_WAIT);
    stb.clearAll   = (state == ST_IDLE) && startCal;
    stb.takeGolden = (state == ST_REF_WAIT) && engDone;
    stb.recordHit  = (state == ST_RD_WAIT) && engDone && sumMatch;
  end

  assign engStart = (state == ST_REF_GO) || (state == ST_RD_GO);
  assign calDone  = (state == ST_FINISH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divIdx <= '0;
      dlyCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE:     if (startCal) state <= ST_REF_GO;
        ST_REF_GO:   state <= ST_REF_WAIT;
        ST_REF_WAIT: if (engDone) begin
                       divIdx <= '0;
                       state  <= ST_PICK;
                     end
        ST_PICK: begin
          if (overCeiling) begin
            if (lastDiv) state <= ST_FINISH;
            else begin
              divIdx <= divIdx + 1'b1;
              state  <= ST_PICK;
            end
          end else begin
            dlyCnt <= '0;
            state  <= ST_RD_GO;
          end
        end
        ST_RD_GO:    state <= ST_RD_WAIT;
        ST_RD_WAIT: if (engDone) begin
          if (sumMatch || int'(dlyCnt) == MDLY) begin
            if (lastDiv) state <= ST_FINISH;
            else begin
              divIdx <= divIdx + 1'b1;
              state  <= ST_PICK;
            end
          end else begin
            dlyCnt <= dlyCnt + 1'b1;
            state  <= ST_RD_GO;
          end
        end
        ST_FINISH:   state <= ST_IDLE;
        default:     state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_tune_dp.sv
module spi_tune_dp
  import spi_tune_pkg::*;
#(
  parameter int SUM_W    = 32,
  parameter int TIMING_W = 32,
  parameter int NDIV     = NUM_DIV
) (
  input  logic                clk,
  input  logic                rstN,
  input  tuneStrobe_t         stb,
  input  logic [SUM_W-1:0]    engSum,
  output logic                sumMatch,
  output logic [CTRL_W-1:0]   engCtrl,
  output logic [TIMING_W-1:0] timingWord,
  output logic [NDIV-1:0]     passMask
);

  localparam int USED_W = NDIV * FIELD_W;

  logic [SUM_W-1:0]   golden;
  logic [FIELD_W-1:0] codeNow;
  logic [FIELD_W-1:0] delayNow;

  assign sumMatch = (engSum == golden);
  assign codeNow  = stb.refMode ? divCode(REF_DIV) : divCode(NDIV - int'(stb.divIdx));
  assign delayNow = stb.refMode ? '0 : (FIELD_W'(stb.dlyCnt) | FIELD_W'(DLY_BIAS));
  assign engCtrl  = {delayNow, codeNow, {FIELD_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN)               golden <= '0;
    else if (stb.takeGolden) golden <= engSum;
  end

  for (genvar k = 0; k < NDIV; k++) begin : g_field
    // field k belongs to divide-by-(k+1)
    logic hitHere;
    assign hitHere = stb.recordHit && (int'(stb.divIdx) == NDIV - 1 - k);
    always_ff @(posedge clk) begin
      if (!rstN || stb.clearAll) begin
        timingWord[k*FIELD_W +: FIELD_W] <= '0;
        passMask[k]                      <= 1'b0;
      end else if (hitHere) begin
        timingWord[k*FIELD_W +: FIELD_W] <= delayNow;
        passMask[k]                      <= 1'b1;
      end
    end
  end

  if (TIMING_W > USED_W) begin : g_pad
    assign timingWord[TIMING_W-1:USED_W] = '0;
  end

endmodule

// File: rtl/spi_read_tuner.sv
module spi_read_tuner
  import spi_tune_pkg::*;
#(
  parameter int SUM_W    = 32,
  parameter int TIMING_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startCal,
  input  logic [FLOOR_W-1:0]  divFloor,
  output logic                engStart,
  output logic [CTRL_W-1:0]   engCtrl,
  input  logic                engDone,
  input  logic [SUM_W-1:0]    engSum,
  output logic                calDone,
  output logic [TIMING_W-1:0] timingWord,
  output logic [NUM_DIV-1:0]  passMask
);

  tuneStrobe_t stb;
  logic        sumMatch;

  spi_tune_ctrl #(.NDIV(NUM_DIV), .MDLY(MAX_DLY)) u_ctrl (
    .clk(clk), .rstN(rstN), .startCal(startCal), .divFloor(divFloor),
    .engDone(engDone), .sumMatch(sumMatch), .stb(stb),
    .engStart(engStart), .calDone(calDone)
  );

  spi_tune_dp #(.SUM_W(SUM_W), .TIMING_W(TIMING_W), .NDIV(NUM_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .engSum(engSum),
    .sumMatch(sumMatch), .engCtrl(engCtrl),
    .timingWord(timingWord), .passMask(passMask)
  );

endmodule

// File: rtl/spi_read_tuner_chk.sv
module spi_read_tuner_chk
  import spi_tune_pkg::*;
#(
  parameter int TIMING_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                startCal,
  input logic                engStart,
  input logic [CTRL_W-1:0]   engCtrl,
  input logic                engDone,
  input logic                calDone,
  input logic [TIMING_W-1:0] timingWord,
  input logic [NUM_DIV-1:0]  passMask
);

  logic running;
  logic rdOpen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      rdOpen  <= 1'b0;
    end else begin
      if (calDone)                   running <= 1'b0;
      else if (startCal && !running) running <= 1'b1;
      if (engStart)     rdOpen <= 1'b1;
      else if (engDone) rdOpen <= 1'b0;
    end
  end

  assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);

  assert_ctrl_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (rdOpen && !engStart) |-> $stable(engCtrl));

  assert_ref_setting_R2: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && engCtrl[7:4] == 4'd0) |-> (engCtrl[11:8] == 4'd0));

  assert_delay_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (engStart && engCtrl[7:4] != 4'd0) |-> (engCtrl[11:8] >= 4'd8 && engCtrl[11:8] <= 4'd13));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    calDone |=> !calDone);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !startCal) |=> ($stable(timingWord) && $stable(passMask)));

  assert_no_read_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> !engStart);

  for (genvar k = 0; k < NUM_DIV; k++) begin : g_fail
    assert_fail_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
      !passMask[k] |-> (timingWord[k*FIELD_W +: FIELD_W] == '0));
  end

endmodule

bind spi_read_tuner spi_read_tuner_chk #(.TIMING_W(TIMING_W)) chk (
  .clk(clk), .rstN(rstN), .startCal(startCal), .engStart(engStart),
  .engCtrl(engCtrl), .engDone(engDone), .calDone(calDone),
  .timingWord(timingWord), .passMask(passMask)
);

// File: tb/spi_read_tuner_test.sv
`timescale 1ns/1ps
module spi_read_tuner_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startCal = 1'b0;
  logic [2:0]  divFloor = 3'd1;
  logic        engStart;
  logic [11:0] engCtrl;
  logic        engDone = 1'b0;
  logic [31:0] engSum = '0;
  logic        calDone;
  logic [31:0] timingWord;
  logic [4:0]  passMask;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  int          goodCnt [1:5];
  logic [31:0] gold = 32'hC0DE_0001;
  logic [11:0] logBuf [0:63];
  int          logCount = 0;
  int          doneHigh = 0;
  bit          startTwice = 0;
  bit          prevStart = 0;

  always #2 clk = ~clk;

  spi_read_tuner uut (
    .clk(clk), .rstN(rstN), .startCal(startCal), .divFloor(divFloor),
    .engStart(engStart), .engCtrl(engCtrl), .engDone(engDone), .engSum(engSum),
    .calDone(calDone), .timingWord(timingWord), .passMask(passMask)
  );

  function automatic logic [3:0] codeOf(int n);
    int v;
    v = (16 - n) >> 1;
    if (n % 2 == 1) v = v | 8;
    return 4'(v);
  endfunction

  function automatic logic [31:0] respond(logic [11:0] c);
    int cnt;
    if (c[7:4] == 4'd0) return gold;
    cnt = int'(c[11:8]) - 8;
    for (int n = 1; n <= 5; n++)
      if (codeOf(n) == c[7:4] && cnt >= goodCnt[n]) return gold;
    return gold ^ (32'h100 | {20'h0, c});
  endfunction

  // engine model
  initial begin
    logic [11:0] held;
    forever begin
      @(negedge clk);
      engDone = 1'b0;
      if (engStart) begin
        held = engCtrl;
        repeat (2) @(negedge clk);
        engSum  = respond(held);
        engDone = 1'b1;
      end
    end
  end

  // monitor and watchdog
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (engStart) begin
        if (logCount < 64) logBuf[logCount] = engCtrl;
        logCount++;
      end
      if (engStart && prevStart) startTwice = 1;
      prevStart = engStart;
      if (calDone) doneHigh++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runCal(string name, int g1, int g2, int g3, int g4, int g5,
                        int floorVal, bit doubleStart);
    logic [11:0] expLog [0:63];
    int          expN;
    logic [31:0] expT;
    logic [4:0]  expP;
    logic [31:0] heldT;
    int          guard;
    goodCnt[1] = g1; goodCnt[2] = g2; goodCnt[3] = g3;
    goodCnt[4] = g4; goodCnt[5] = g5;
    gold = gold + 32'h1111;
    // expected behaviour from the requirements
    expN = 1; expLog[0] = 12'h000; expT = '0; expP = '0;
    for (int n = 5; n >= 1; n--) begin
      if (n < floorVal) continue;
      for (int c = 0; c <= 5; c++) begin
        expLog[expN] = {4'(c + 8), codeOf(n), 4'h0};
        expN++;
        if (c >= goodCnt[n]) begin
          expT[(n-1)*4 +: 4] = 4'(c + 8);
          expP[n-1] = 1'b1;
          break;
        end
      end
    end
    @(negedge clk);
    divFloor = 3'(floorVal);
    logCount = 0; doneHigh = 0; startTwice = 0;
    startCal = 1'b1;
    @(negedge clk);
    startCal = 1'b0;
    if (doubleStart) begin
      repeat (8) @(negedge clk);
      startCal = 1'b1;          // R9: ignored while running
      @(negedge clk);
      startCal = 1'b0;
    end
    guard = 0;
    while (doneHigh == 0 && guard < 2000) begin @(negedge clk); guard++; end
    @(negedge clk);
    chk({name, " R8 done pulse"}, 32'(doneHigh), 32'd1);
    chk({name, " R5 timing word"}, timingWord, expT);
    chk({name, " R6 pass mask"}, {27'h0, passMask}, {27'h0, expP});
    chk({name, " R9 read count"}, 32'(logCount), 32'(expN));
    chk({name, " R10 start pulse width"}, {31'h0, startTwice}, 32'd0);
    for (int i = 0; i < expN && i < 64; i++)
      chk({name, (i == 0) ? " R2 ref ctrl" : " R3 R4 ctrl order"},
          {20'h0, logBuf[i]}, {20'h0, expLog[i]});
    heldT = timingWord;
    repeat (20) @(negedge clk);
    chk({name, " R8 result held"}, timingWord, heldT);
    chk({name, " R8 upper bits zero"}, {20'h0, timingWord[31:20]}, 32'd0);
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    chk("R1 timingWord", timingWord, 32'd0);
    chk("R1 passMask", {27'h0, passMask}, 32'd0);
    chk("R1 calDone", {31'h0, calDone}, 32'd0);
    chk("R1 engStart", {31'h0, engStart}, 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", {27'h0, passMask} | timingWord, 32'd0);
  endtask

  initial begin
    testReset();
    runCal("all-first", 0, 0, 0, 0, 0, 1, 0);
    runCal("mixed", 3, 6, 5, 2, 0, 1, 0);          // R6: divide-by-2 fails
    runCal("ceiling", 1, 1, 1, 1, 1, 3, 0);        // R7: 1 and 2 skipped
    runCal("all-fail", 6, 6, 6, 6, 6, 1, 0);
    runCal("restart-busy", 0, 0, 0, 0, 0, 1, 1);   // R9
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule